// File: doc/BRIEF.md
# Sigma-Delta Bitstream Decimator

This block converts the one-bit density stream from a first-order sigma-delta modulator into 6-bit unsigned words. It produces one word for every eight accepted input bits. Each input bit arrives with a valid strobe. Cycles without the strobe are idle and change nothing.

The chain has three filtering stages, then decimation and rounding.

- The first stage is a symmetric 65-tap FIR whose coefficients are built so that the filter runs as a recursive accumulator. Each sample the accumulator gains one 7-bit magnitude and loses another. Both magnitudes are formed by wiring taps from a one-bit delay line, so the stage needs only two adders and no multipliers. It also shapes the passband to offset the droop of the later stages.
- Two moving-sum sections of lengths 10 and 16 follow. Each is built as a wrapping integrator and a comb.
- A selector keeps every eighth result.
- The kept result is divided by 1024 with round-half-up and clamped to the 6-bit range.

Each stage registers its result together with a valid bit. A kept word therefore leaves the block a fixed number of clocks after the input bit that completed it.

Top module: `sdm_decimator`

## Requirements
- R1: During reset and right after it, `word_vld` is 0 and `word_out` is 0. After every reset, all filter history is cleared, so the following words are computed as if every earlier input bit were 0.
- R2: For the n-th accepted bit x[n], the FIR value is y[n] = sum over k = 0..64 of h[k]·x[n-k], with h[k] = h[64-k]. The first half h[0..32] is: -2 (nine times), 14 (six times), -18, -17 (eleven times), 47, 55 (four times), 51. The value y[n] always lies in [-446, 753].
- R3: A cycle with `bit_vld` = 0 ignores `bit_in` and advances no state. `word_out` keeps its value between strobes.
- R4: The second stage outputs s[n] = y[n] + y[n-1] + ... + y[n-9], a moving sum of ten FIR values.
- R5: The third stage outputs v[n] = s[n] + s[n-1] + ... + s[n-15], a moving sum of sixteen second-stage values.
- R6: `word_vld` pulses for exactly one cycle for accepted bits number 8, 16, 24, … counting from 1 after reset, and at no other time.
- R7: If accepted bit number 8m is sampled on clock edge E, `word_vld` is high from edge E+3 until edge E+4.
- R8: The word is min(63, max(0, floor((v + 512) / 1024))), where v is the third-stage value for that bit. A constant run of ones therefore settles at 48.
- R9: A result whose rounded value is negative is output as 0 and does not wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_vld | input | 1 | Marks a modulator bit in this cycle |
| bit_in | input | 1 | Modulator bit |
| word_vld | output | 1 | One-cycle strobe for a new output word |
| word_out | output | 6 | Decimated, rounded unsigned word |

## Verification
The FIR accumulator and both integrators are recursive. A single wrong increment, a mis-wired tap or a missed reset therefore offsets every later word, not just one. The error shows at the next strobe, at most eight accepted bits later. A fault in a comb history or in the delay line corrupts words only while the bad value is inside the window: up to 16 samples for the combs and 65 samples for the delay line. A wrong strobe phase or a wrong latency moves the strobe away from its expected edge, and the bench sees this on the first output word.

// File: rtl/sdm_dec_pkg.sv
package sdm_dec_pkg;
   // FIR order and tap count
   localparam int FIR_ORDER = 64;
   localparam int FIR_TAPS  = FIR_ORDER + 1;
   // one bit of each step magnitude per transition point on each side
   localparam int TP_BITS   = 7;
   // delay (in samples) of the input bit that sets bit b of the rising magnitude
   localparam int UP_TAP [TP_BITS] = '{16, 65, 33, 28, 9, 50, 27};
   // delay of the input bit that sets bit b of the falling magnitude
   localparam int DN_TAP [TP_BITS] = '{49, 0, 32, 37, 56, 15, 38};
   // extreme FIR results: sums of positive and of negative coefficients
   localparam int FIR_PEAK_POS = 753;
   localparam int FIR_PEAK_NEG = -446;
   localparam int FIR_MIN_W    = 11;
endpackage

// File: rtl/sdm_dec_fir.sv
module sdm_dec_fir
   import sdm_dec_pkg::*;
#(
   parameter int OUT_W = 11
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_vld,
   input  logic                    in_bit,
   output logic                    out_vld,
   output logic signed [OUT_W-1:0] out_dat
);
   localparam int STEP_W = TP_BITS + 1;

   if (OUT_W < FIR_MIN_W) begin : g_bad_w
      $error("sdm_dec_fir: OUT_W too small for the FIR range");
   end

   // dly[j] holds the input bit from j+1 accepted samples ago
   logic [FIR_TAPS-1:0]     dly;
   logic [TP_BITS-1:0]      up_mag;
   logic [TP_BITS-1:0]      dn_mag;
   logic signed [STEP_W-1:0] step;
   logic signed [OUT_W-1:0]  acc_nxt;

   for (genvar b = 0; b < TP_BITS; b++) begin : g_tp
      if (UP_TAP[b] == 0) begin : g_up_now
         assign up_mag[b] = in_bit;
      end else begin : g_up_dly
         assign up_mag[b] = dly[UP_TAP[b]-1];
      end
      if (DN_TAP[b] == 0) begin : g_dn_now
         assign dn_mag[b] = in_bit;
      end else begin : g_dn_dly
         assign dn_mag[b] = dly[DN_TAP[b]-1];
      end
   end

   // first adder: signed step from the two magnitudes
   assign step    = $signed({1'b0, up_mag}) - $signed({1'b0, dn_mag});
   // second adder: recursive accumulation
   assign acc_nxt = out_dat + {{(OUT_W-STEP_W){step[STEP_W-1]}}, step};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dly     <= '0;
         out_dat <= '0;
         out_vld <= 1'b0;
      end else begin
         out_vld <= in_vld;
         if (in_vld) begin
            dly     <= {dly[FIR_TAPS-2:0], in_bit};
            out_dat <= acc_nxt;
         end
      end
   end

   // R2
   fir_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_dat <= FIR_PEAK_POS) && (out_dat >= FIR_PEAK_NEG));
   // R3
   fir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_vld |=> $stable(out_dat) && !out_vld);
   // R7
   fir_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_vld |=> out_vld);
endmodule

// File: rtl/sdm_dec_movsum.sv
module sdm_dec_movsum #(
   parameter int LEN = 10,
   parameter int W   = 19
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_vld,
   input  logic signed [W-1:0] in_dat,
   output logic                out_vld,
   output logic signed [W-1:0] out_dat
);
   if (LEN < 2) begin : g_bad_len
      $error("sdm_dec_movsum: LEN must be at least 2");
   end

   // hist[i] = wrapping integrator value from i+1 samples ago
   logic signed [W-1:0] hist [LEN];
   logic signed [W-1:0] run_nxt;

   assign run_nxt = hist[0] + in_dat;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < LEN; i++) hist[i] <= '0;
         out_dat <= '0;
         out_vld <= 1'b0;
      end else begin
         out_vld <= in_vld;
         if (in_vld) begin
            hist[0] <= run_nxt;
            for (int i = 1; i < LEN; i++) hist[i] <= hist[i-1];
            out_dat <= run_nxt - hist[LEN-1];
         end
      end
   end

   // R7
   ms_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_vld |=> out_vld);
   // R3
   ms_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_vld |=> !out_vld && $stable(out_dat));
endmodule

// File: rtl/sdm_dec_pick.sv
module sdm_dec_pick #(
   parameter int FACTOR = 8,
   parameter int IN_W   = 19,
   parameter int OUT_W  = 6,
   parameter int RSHIFT = 10
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   in_vld,
   input  logic signed [IN_W-1:0] in_dat,
   output logic                   out_vld,
   output logic [OUT_W-1:0]       out_dat
);
   localparam int CNT_W = (FACTOR > 2) ? $clog2(FACTOR) : 1;
   localparam logic signed [IN_W:0] HALF = (IN_W+1)'(1) <<< (RSHIFT-1);
   localparam logic signed [IN_W:0] TOP  = (IN_W+1)'((1 << OUT_W) - 1);

   if (FACTOR < 2) begin : g_bad_fac
      $error("sdm_dec_pick: FACTOR must be at least 2");
   end
   if (RSHIFT < 1 || RSHIFT >= IN_W) begin : g_bad_sh
      $error("sdm_dec_pick: RSHIFT out of range");
   end

   logic [CNT_W-1:0]     cnt;
   logic signed [IN_W:0] biased;
   logic signed [IN_W:0] quot;
   logic [OUT_W-1:0]     word;

   assign biased = $signed({in_dat[IN_W-1], in_dat}) + HALF;
   assign quot   = biased >>> RSHIFT;

   always_comb begin
      if (quot < 0)         word = '0;
      else if (quot > TOP)  word = '1;
      else                  word = quot[OUT_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         out_vld <= 1'b0;
         out_dat <= '0;
      end else begin
         out_vld <= 1'b0;
         if (in_vld) begin
            if (cnt == CNT_W'(FACTOR-1)) begin
               cnt     <= '0;
               out_vld <= 1'b1;
               out_dat <= word;
            end else begin
               cnt <= cnt + CNT_W'(1);
            end
         end
      end
   end

   // R6
   pick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld |=> !out_vld);
   // R3
   pick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_vld |=> !out_vld && $stable(out_dat));
endmodule

// File: rtl/sdm_decimator.sv
module sdm_decimator
   import sdm_dec_pkg::*;
#(
   parameter int FIR_W  = 11,
   parameter int LEN_A  = 10,
   parameter int LEN_B  = 16,
   parameter int FACTOR = 8,
   parameter int OUT_W  = 6,
   parameter int RSHIFT = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_vld,
   input  logic             bit_in,
   output logic             word_vld,
   output logic [OUT_W-1:0] word_out
);
   localparam int NSTG  = 2;
   localparam int ACC_W = FIR_W + $clog2(LEN_A * LEN_B);
   localparam int STAGE_LEN [NSTG] = '{LEN_A, LEN_B};

   if (RSHIFT >= ACC_W) begin : g_bad_sh
      $error("sdm_decimator: RSHIFT exceeds accumulator width");
   end

   logic                    fir_vld;
   logic signed [FIR_W-1:0] fir_dat;
   logic [NSTG:0]           st_vld;
   logic [NSTG:0][ACC_W-1:0] st_dat;

   sdm_dec_fir #(.OUT_W(FIR_W)) u_fir (
      .clk     (clk),
      .rst_n   (rst_n),
      .in_vld  (bit_vld),
      .in_bit  (bit_in),
      .out_vld (fir_vld),
      .out_dat (fir_dat)
   );

   assign st_vld[0] = fir_vld;
   assign st_dat[0] = {{(ACC_W-FIR_W){fir_dat[FIR_W-1]}}, fir_dat};

   // R4, R5: cascaded moving-sum sections
   for (genvar s = 0; s < NSTG; s++) begin : g_stage
      logic signed [ACC_W-1:0] sum_o;
      sdm_dec_movsum #(.LEN(STAGE_LEN[s]), .W(ACC_W)) u_sum (
         .clk     (clk),
         .rst_n   (rst_n),
         .in_vld  (st_vld[s]),
         .in_dat  ($signed(st_dat[s])),
         .out_vld (st_vld[s+1]),
         .out_dat (sum_o)
      );
      assign st_dat[s+1] = sum_o;
   end

   sdm_dec_pick #(
      .FACTOR (FACTOR),
      .IN_W   (ACC_W),
      .OUT_W  (OUT_W),
      .RSHIFT (RSHIFT)
   ) u_pick (
      .clk     (clk),
      .rst_n   (rst_n),
      .in_vld  (st_vld[NSTG]),
      .in_dat  ($signed(st_dat[NSTG])),
      .out_vld (word_vld),
      .out_dat (word_out)
   );
endmodule

// File: tb/sdm_decimator_bench.sv
module sdm_decimator_bench;
   localparam int MAXN = 4096;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bit_vld = 1'b0;
   logic       bit_in = 1'b0;
   logic       word_vld;
   logic [5:0] word_out;

   always #4 clk = ~clk;

   sdm_decimator u_sdm_decimator (
      .clk      (clk),
      .rst_n    (rst_n),
      .bit_vld  (bit_vld),
      .bit_in   (bit_in),
      .word_vld (word_vld),
      .word_out (word_out)
   );

   int    checks = 0;
   int    errors = 0;
   int    edge_cnt = 0;
   bit    mon_on = 1'b0;
   bit    done = 1'b0;
   int    xs [MAXN];
   int    ys [MAXN];
   int    s1 [MAXN];
   int    n_samp = 0;
   int    exp_edge [$];
   int    exp_val [$];
   string exp_tag [$];
   string cur_tag = "R2/R4/R5/R8 word value";
   int    last_word = 0;
   int    raw_last = 0;

   always @(posedge clk) edge_cnt++;

   task automatic check(input bit ok, input string tag, input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", tag, act, expv);
      end
   endtask

   // R2 coefficient from its segment description
   function automatic int coef(input int k);
      int m;
      m = (k > 32) ? 64 - k : k;
      if (m < 9)       return -2;
      else if (m < 15) return 14;
      else if (m == 15) return -18;
      else if (m < 27) return -17;
      else if (m == 27) return 47;
      else if (m < 32) return 55;
      else             return 51;
   endfunction

   function automatic int round_raw(input int v);
      return (v + 512) >>> 10;
   endfunction

   function automatic int clampw(input int q);
      if (q < 0)  return 0;
      if (q > 63) return 63;
      return q;
   endfunction

   task automatic push(input bit b);
      int n;
      int y;
      int a;
      int v;
      n = n_samp; y = 0; a = 0; v = 0;
      xs[n] = b;
      for (int k = 0; k <= 64; k++) if (n - k >= 0) y += coef(k) * xs[n-k];
      ys[n] = y;
      for (int i = 0; i < 10; i++) if (n - i >= 0) a += ys[n-i];
      s1[n] = a;
      for (int i = 0; i < 16; i++) if (n - i >= 0) v += s1[n-i];
      if (n % 8 == 7) begin
         raw_last = round_raw(v);
         exp_edge.push_back(edge_cnt + 4);
         exp_val.push_back(clampw(raw_last));
         exp_tag.push_back(cur_tag);
      end
      n_samp++;
      bit_vld = 1'b1;
      bit_in  = b;
      @(negedge clk);
   endtask

   task automatic idle(input int c);
      repeat (c) begin
         bit_vld = 1'b0;
         bit_in  = 1'($urandom % 2);
         @(negedge clk);
      end
   endtask

   task automatic push_mix(input bit b, input int gap_pct);
      if (int'($urandom % 100) < gap_pct) idle(1 + int'($urandom % 3));
      push(b);
   endtask

   task automatic do_reset();
      mon_on  = 1'b0;
      bit_vld = 1'b0;
      rst_n   = 1'b0;
      repeat (3) @(negedge clk);
      check(word_vld == 1'b0, "R1 strobe low in reset", int'(word_vld), 0);
      check(word_out == 6'd0, "R1 word zero in reset", int'(word_out), 0);
      rst_n = 1'b1;
      n_samp = 0;
      exp_edge.delete();
      exp_val.delete();
      exp_tag.delete();
      last_word = 0;
      @(negedge clk);
      check(word_vld == 1'b0, "R1 strobe low after reset", int'(word_vld), 0);
      check(word_out == 6'd0, "R1 word zero after reset", int'(word_out), 0);
      mon_on = 1'b1;
   endtask

   always @(negedge clk) begin
      int    e;
      int    v;
      string t;
      if (mon_on) begin
         if (word_vld) begin
            if (exp_edge.size() == 0) begin
               check(1'b0, "R6 unexpected word strobe", edge_cnt, -1);
            end else begin
               e = exp_edge.pop_front();
               v = exp_val.pop_front();
               t = exp_tag.pop_front();
               check(edge_cnt == e, "R7 strobe timing", edge_cnt, e);
               check(int'(word_out) == v, t, int'(word_out), v);
               last_word = int'(word_out);
            end
         end else begin
            if (exp_edge.size() > 0 && exp_edge[0] <= edge_cnt) begin
               check(1'b0, "R6 missing word strobe", edge_cnt, exp_edge[0]);
               e = exp_edge.pop_front();
               v = exp_val.pop_front();
               t = exp_tag.pop_front();
            end
            check(int'(word_out) == last_word, "R3 word held between strobes",
                  int'(word_out), last_word);
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual %0d expected %0d", edge_cnt, 0);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int acc;
      int level;
      void'($urandom(32'd4711));
      @(negedge clk);
      do_reset();

      // R1: zero input from cleared history
      cur_tag = "R1 zero history word";
      for (int i = 0; i < 64; i++) push(1'b0);

      // R8: full density settles at 48
      cur_tag = "R2/R4/R5/R8 all-ones word";
      for (int i = 0; i < 400; i++) push(1'b1);
      idle(6);
      check(last_word == 48, "R8 full-density level", last_word, 48);

      // R3: modulator-like stream with idle gaps and junk bits
      cur_tag = "R3/R4/R5 word with idle gaps";
      acc = 0;
      for (int seg = 0; seg < 6; seg++) begin
         level = int'($urandom % 256);
         for (int i = 0; i < 200; i++) begin
            acc += level;
            if (acc >= 256) begin
               acc -= 256;
               push_mix(1'b1, 25);
            end else begin
               push_mix(1'b0, 25);
            end
         end
      end

      // R9: short burst after silence drives the rounded result negative
      cur_tag = "R2/R8 quiet before burst";
      for (int i = 0; i < 100; i++) push(1'b0);
      while (n_samp % 8 != 3) push(1'b0);
      cur_tag = "R9 lower clamp word";
      for (int i = 0; i < 13; i++) push(1'b1);
      check(raw_last < 0, "R9 stimulus gives negative rounding", raw_last, -1);
      cur_tag = "R2/R4/R5/R8 word after burst";
      for (int i = 0; i < 40; i++) push(1'b0);

      // R2, R4, R5, R8: random bits with random gaps
      cur_tag = "R2/R4/R5/R8 random word";
      for (int i = 0; i < 1500; i++) push_mix(1'($urandom % 2), 15);

      // R1: reset mid-stream clears all history
      idle(12);
      check(exp_edge.size() == 0, "R6 all words delivered", exp_edge.size(), 0);
      do_reset();
      cur_tag = "R1 word after second reset";
      for (int i = 0; i < 240; i++) push_mix(1'($urandom % 2), 10);
      idle(12);
      check(exp_edge.size() == 0, "R6 all words delivered at end", exp_edge.size(), 0);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule